// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the instruction decoder and sequencer behind a byte-oriented serial front-end for a 512-byte nonvolatile memory. The memory is modelled as an internal register array. The front-end delivers each received byte with a one-cycle strobe. It reports when the chip-select frame opens and closes, and whether the frame closed with a byte only partly shifted in. The engine decodes the opening byte as an instruction and then handles the rest of the frame. It sets or clears the write-enable latch, returns status bytes, streams memory bytes from an auto-incrementing address, or stages write data.

Memory writes are gathered in a 16-byte page buffer. Nothing reaches the array until the frame closes cleanly. At that point the engine checks the write-enable latch, the idle state and a write-allowed input from an external protection unit. If all three permit it, a self-timed write cycle starts and lasts a parameterised number of system clocks. The staged bytes land in the array when that cycle ends, and the latch is cleared at the same moment. Status writes follow the same path and update the protection-enable bit and the two block-protect bits. These bits are driven out to the protection unit.

Top module: `eeCmdEngine`

## Requirements
- R1: After reset, busy, protEnable and blockProt are 0, txData is 0xFF, and a status read returns 0x00.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1). Opcode 0x04 clears it. The effect is visible on the next status read.
- R3: Opcode 0x05 makes txData present the status byte from the cycle after the opcode strobe until the frame ends. The status byte is bit 7 protection enable, bits 6:4 zero, bits 3:2 block protect, bit 1 write-enable latch, bit 0 busy.
- R4: Opcode 0000_A011 starts a read. A is address bit 8, and the next byte gives bits 7:0. In the cycle after the address strobe, txData holds that location. Each later byte strobe advances the address, and 0x1FF wraps to 0x000.
- R5: Opcode 0000_A010 followed by an address byte stages data into the 16-byte page named by address bits 8:4, and stagedPage shows that page. Bytes past column 15 wrap to column 0 of the same page, so that the last 16 bytes win. Nothing is committed before the frame closes.
- R6: A staged write commits only if, when the frame closes, the write-enable latch is 1 and writeAllowed is 1. Otherwise it is dropped: no busy period, the array is unchanged and the latch is kept.
- R7: A write frame that closes with midByte high, or after no data byte, is dropped.
- R8: A committed write raises busy in the cycle after the frame closes and holds it for exactly WR_CYCLES clocks. The array holds the new data once busy falls.
- R9: The write-enable latch is 0 after every completed write cycle.
- R10: While busy, every opcode except 0x05 is ignored. A read presents 0xFF and a latch opcode has no effect.
- R11: Opcode 0x01 followed by a data byte stages bit 7 into protEnable and bits 3:2 into blockProt. These take effect at the end of a write cycle gated as in R6, R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameActive | input | 1 | High while the select frame is open |
| rxValid | input | 1 | One-cycle strobe: rxByte holds a complete received byte |
| rxByte | input | 8 | Received byte |
| midByte | input | 1 | Valid in the first cycle frameActive is low: frame closed mid-byte |
| writeAllowed | input | 1 | Protection unit verdict for the staged write |
| txData | output | 8 | Byte for the front-end to shift out next |
| busy | output | 1 | Self-timed write cycle in progress |
| protEnable | output | 1 | Stored protection-enable bit |
| blockProt | output | 2 | Stored block-protect bits |
| stagedPage | output | 5 | Page (address bits 8:4) of the staged write |

## Verification
The assertions rely on the front-end's rules for its inputs. A byte strobe arrives only while the frame is open and never in the frame's first cycle. midByte is meaningful only in the cycle the frame closes. writeAllowed stays steady around that cycle. The bench follows these rules by design: every input changes on the falling clock edge, each frame opens and is then idle for one cycle before its first byte, and each strobe lasts a single cycle. midByte is raised only together with the closing of the frame.

// File: rtl/eeCmdPkg.sv
package eeCmdPkg;
  localparam int EE_ADDR_W = 9;

  localparam logic [7:0] OP_LATCH_ON  = 8'h06;
  localparam logic [7:0] OP_LATCH_OFF = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [2:0] OP_MEM_RD_LO = 3'b011;
  localparam logic [2:0] OP_MEM_WR_LO = 3'b010;

  typedef enum logic [1:0] {TX_IDLE, TX_STAT, TX_MEM} txSel_e;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadAddr;
    logic incAddr;
    logic openPage;
    logic stageByte;
    logic stageStat;
    logic commitMem;
    logic commitStat;
  } eeStrobe_t;
endpackage

// File: rtl/eeCmdCtrl.sv
module eeCmdCtrl
  import eeCmdPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameActive,
  input  logic                 rxValid,
  input  logic [7:0]           rxByte,
  input  logic                 midByte,
  input  logic                 writeAllowed,
  input  logic                 busy,
  input  logic                 wel,
  input  logic                 pageHasData,
  output eeStrobe_t            stb,
  output txSel_e               txSel,
  output logic [EE_ADDR_W-1:0] addrLoad
);
  typedef enum logic [3:0] {
    S_IDLE, S_OP, S_SKIP, S_STAT, S_RADDR, S_READ,
    S_WADDR, S_WDATA, S_SDATA, S_SDONE
  } state_e;

  state_e state, nxt;
  logic   prevActive;
  logic   addrHi;
  logic   frameClose;
  logic   cleanClose;
  logic   isMemRd;
  logic   isMemWr;

  assign frameClose = prevActive && !frameActive;
  assign cleanClose = frameClose && !midByte && wel && writeAllowed && !busy;
  assign isMemRd    = (rxByte[7:4] == 4'h0) && (rxByte[2:0] == OP_MEM_RD_LO);
  assign isMemWr    = (rxByte[7:4] == 4'h0) && (rxByte[2:0] == OP_MEM_WR_LO);
  assign addrLoad   = {addrHi, rxByte};

  always_comb begin
    stb = '0;
    nxt = state;
    if (!frameActive) begin
      nxt = S_IDLE;
      if (cleanClose && state == S_WDATA && pageHasData) stb.commitMem = 1'b1;
      if (cleanClose && state == S_SDONE) stb.commitStat = 1'b1;
    end else if (!prevActive) begin
      nxt = S_OP;
    end else if (rxValid) begin
      case (state)
        S_OP: begin
          nxt = S_SKIP;
          if (rxByte == OP_STAT_RD) begin
            nxt = S_STAT;
          end else if (!busy) begin
            if (rxByte == OP_LATCH_ON)       stb.setWel = 1'b1;
            else if (rxByte == OP_LATCH_OFF) stb.clrWel = 1'b1;
            else if (rxByte == OP_STAT_WR)   nxt = S_SDATA;
            else if (isMemRd)                nxt = S_RADDR;
            else if (isMemWr)                nxt = S_WADDR;
          end
        end
        S_RADDR: begin
          stb.loadAddr = 1'b1;
          nxt = S_READ;
        end
        S_READ:  stb.incAddr = 1'b1;
        S_WADDR: begin
          stb.loadAddr = 1'b1;
          stb.openPage = 1'b1;
          nxt = S_WDATA;
        end
        S_WDATA: stb.stageByte = 1'b1;
        S_SDATA: begin
          stb.stageStat = 1'b1;
          nxt = S_SDONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      prevActive <= 1'b0;
      addrHi     <= 1'b0;
    end else begin
      state      <= nxt;
      prevActive <= frameActive;
      if (state == S_OP && rxValid && frameActive && prevActive) addrHi <= rxByte[3];
    end
  end

  always_comb begin
    case (state)
      S_STAT:  txSel = TX_STAT;
      S_READ:  txSel = TX_MEM;
      default: txSel = TX_IDLE;
    endcase
  end

  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_OP && rxValid && frameActive && prevActive && busy && rxByte != OP_STAT_RD)
      |=> (state == S_SKIP && $stable(addrHi) || state == S_SKIP));

  // R7
  mid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameClose && midByte) |=> !$rose(busy));
endmodule

// File: rtl/eeCmdData.sv
module eeCmdData
  import eeCmdPkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 640
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  eeStrobe_t                   stb,
  input  txSel_e                      txSel,
  input  logic [EE_ADDR_W-1:0]        addrLoad,
  input  logic [7:0]                  rxByte,
  output logic [7:0]                  txData,
  output logic                        busy,
  output logic                        wel,
  output logic                        pageHasData,
  output logic                        protEnable,
  output logic [1:0]                  blockProt,
  output logic [EE_ADDR_W-PAGE_W-1:0] stagedPage
);
  localparam int DEPTH      = 1 << EE_ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BASE_W     = EE_ADDR_W - PAGE_W;
  localparam int TMR_W      = $clog2(WR_CYCLES + 1);

  logic [7:0]            mem [DEPTH];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageMask;
  logic [PAGE_W-1:0]     pageCol;
  logic [BASE_W-1:0]     pageBase;
  logic [EE_ADDR_W-1:0]  rdAddr;
  logic [TMR_W-1:0]      timer;
  logic                  pendStat;
  logic                  nextWpen;
  logic [1:0]            nextBp;
  logic                  cycleDone;

  assign cycleDone   = busy && (timer == '0);
  assign pageHasData = |pageMask;
  assign stagedPage  = pageBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr     <= '0;
      pageMask   <= '0;
      pageCol    <= '0;
      pageBase   <= '0;
      timer      <= '0;
      busy       <= 1'b0;
      pendStat   <= 1'b0;
      wel        <= 1'b0;
      nextWpen   <= 1'b0;
      nextBp     <= '0;
      protEnable <= 1'b0;
      blockProt  <= '0;
    end else begin
      if (stb.loadAddr)     rdAddr <= addrLoad;
      else if (stb.incAddr) rdAddr <= rdAddr + 1'b1;

      if (stb.openPage) begin
        pageBase <= addrLoad[EE_ADDR_W-1:PAGE_W];
        pageCol  <= addrLoad[PAGE_W-1:0];
        pageMask <= '0;
      end else if (stb.stageByte) begin
        pageMask[pageCol] <= 1'b1;
        pageCol           <= pageCol + 1'b1;
      end

      if (stb.stageStat) begin
        nextWpen <= rxByte[7];
        nextBp   <= rxByte[3:2];
      end

      if (stb.setWel)      wel <= 1'b1;
      else if (stb.clrWel) wel <= 1'b0;

      if (stb.commitMem || stb.commitStat) begin
        busy     <= 1'b1;
        timer    <= TMR_W'(WR_CYCLES - 1);
        pendStat <= stb.commitStat;
      end else if (cycleDone) begin
        busy <= 1'b0;
        wel  <= 1'b0;
        if (pendStat) begin
          protEnable <= nextWpen;
          blockProt  <= nextBp;
        end
      end else if (busy) begin
        timer <= timer - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.stageByte) pageBuf[pageCol] <= rxByte;
  end

  always_ff @(posedge clk) begin
    if (cycleDone && !pendStat) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pageMask[i]) mem[{pageBase, PAGE_W'(i)}] <= pageBuf[i];
      end
    end
  end

  always_comb begin
    case (txSel)
      TX_STAT: txData = {protEnable, 3'b000, blockProt, wel, busy};
      TX_MEM:  txData = mem[rdAddr];
      default: txData = 8'hFF;
    endcase
  end

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stb.commitMem || stb.commitStat));

  // R9
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);

  // R4
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incAddr && !stb.loadAddr && rdAddr == '1) |=> (rdAddr == '0));

  // R5
  stage_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.stageByte |=> pageHasData);
endmodule

// File: rtl/eeCmdEngine.sv
module eeCmdEngine
  import eeCmdPkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 640
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        frameActive,
  input  logic                        rxValid,
  input  logic [7:0]                  rxByte,
  input  logic                        midByte,
  input  logic                        writeAllowed,
  output logic [7:0]                  txData,
  output logic                        busy,
  output logic                        protEnable,
  output logic [1:0]                  blockProt,
  output logic [EE_ADDR_W-PAGE_W-1:0] stagedPage
);
  eeStrobe_t            stb;
  txSel_e               txSel;
  logic [EE_ADDR_W-1:0] addrLoad;
  logic                 wel;
  logic                 pageHasData;

  eeCmdCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameActive  (frameActive),
    .rxValid      (rxValid),
    .rxByte       (rxByte),
    .midByte      (midByte),
    .writeAllowed (writeAllowed),
    .busy         (busy),
    .wel          (wel),
    .pageHasData  (pageHasData),
    .stb          (stb),
    .txSel        (txSel),
    .addrLoad     (addrLoad)
  );

  eeCmdData #(
    .PAGE_W    (PAGE_W),
    .WR_CYCLES (WR_CYCLES)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .txSel       (txSel),
    .addrLoad    (addrLoad),
    .rxByte      (rxByte),
    .txData      (txData),
    .busy        (busy),
    .wel         (wel),
    .pageHasData (pageHasData),
    .protEnable  (protEnable),
    .blockProt   (blockProt),
    .stagedPage  (stagedPage)
  );
endmodule

// File: tb/eeCmdEngine_test.sv
`timescale 1ns/1ps
module eeCmdEngine_test;
  localparam int WR = 200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameActive = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       midByte = 1'b0;
  logic       writeAllowed = 1'b1;
  logic [7:0] txData;
  logic       busy;
  logic       protEnable;
  logic [1:0] blockProt;
  logic [4:0] stagedPage;

  int compared = 0;
  int mismatched = 0;

  eeCmdEngine #(.PAGE_W(4), .WR_CYCLES(WR)) uut (
    .clk(clk), .rstN(rstN), .frameActive(frameActive), .rxValid(rxValid),
    .rxByte(rxByte), .midByte(midByte), .writeAllowed(writeAllowed),
    .txData(txData), .busy(busy), .protEnable(protEnable),
    .blockProt(blockProt), .stagedPage(stagedPage)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic startFrame();
    @(negedge clk) frameActive = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxByte = b;
    rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic endFrame(input logic mid);
    frameActive = 1'b0;
    midByte = mid;
    @(negedge clk);
    midByte = 1'b0;
  endtask

  task automatic oneByteCmd(input logic [7:0] op);
    startFrame();
    sendByte(op);
    endFrame(1'b0);
  endtask

  task automatic readStatus(output logic [7:0] v);
    startFrame();
    sendByte(8'h05);
    v = txData;
    endFrame(1'b0);
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic writeOpen(input logic [8:0] a);
    startFrame();
    sendByte({4'h0, a[8], 3'b010});
    sendByte(a[7:0]);
  endtask

  task automatic writeSeq(input logic [8:0] a, input int n, input logic [7:0] base);
    writeOpen(a);
    for (int k = 0; k < n; k++) sendByte(base + 8'(k));
    endFrame(1'b0);
  endtask

  task automatic readOpen(input logic [8:0] a);
    startFrame();
    sendByte({4'h0, a[8], 3'b011});
    sendByte(a[7:0]);
  endtask

  task automatic readOne(input string req, input logic [8:0] a, input logic [7:0] exp);
    readOpen(a);
    check(req, txData, exp);
    endFrame(1'b0);
  endtask

  task automatic testReset();
    logic [7:0] s;
    check("R1 busy", busy, 0);
    check("R1 protEnable", protEnable, 0);
    check("R1 blockProt", blockProt, 0);
    check("R1 idle txData", txData, 8'hFF);
    readStatus(s);
    check("R1 R3 status", s, 8'h00);
  endtask

  task automatic testLatch();
    logic [7:0] s;
    oneByteCmd(8'h06);
    readStatus(s);
    check("R2 latch on", s, 8'h02);
    oneByteCmd(8'h04);
    readStatus(s);
    check("R2 latch off", s, 8'h00);
  endtask

  task automatic testWriteRead();
    logic [7:0] s;
    int n;
    oneByteCmd(8'h06);
    writeSeq(9'h000, 2, 8'h10);
    check("R8 busy raised", busy, 1);
    waitIdle(n);
    check("R8 busy length", n, WR);
    readStatus(s);
    check("R9 latch cleared", s, 8'h00);
    oneByteCmd(8'h06);
    writeOpen(9'h1FE);
    check("R5 stagedPage", stagedPage, 5'h1F);
    for (int k = 0; k < 3; k++) sendByte(8'hA0 + 8'(k));
    check("R5 no commit before close", busy, 0);
    endFrame(1'b0);
    waitIdle(n);
    readOpen(9'h1FE);
    check("R4 first byte", txData, 8'hA0);
    sendByte(8'h00);
    check("R4 increment", txData, 8'hA1);
    sendByte(8'h00);
    check("R4 wrap to 0x000", txData, 8'h10);
    sendByte(8'h00);
    check("R4 after wrap", txData, 8'h11);
    endFrame(1'b0);
    readOne("R5 page wrap", 9'h1F0, 8'hA2);
  endtask

  task automatic testOverflow();
    int n;
    oneByteCmd(8'h06);
    writeSeq(9'h020, 18, 8'h40);
    waitIdle(n);
    readOpen(9'h020);
    check("R5 last16 col0", txData, 8'h50);
    sendByte(8'h00);
    check("R5 last16 col1", txData, 8'h51);
    sendByte(8'h00);
    check("R5 last16 col2", txData, 8'h42);
    endFrame(1'b0);
    readOne("R5 last16 col15", 9'h02F, 8'h4F);
  endtask

  task automatic testGating();
    logic [7:0] s;
    writeSeq(9'h000, 1, 8'h99);
    check("R6 no latch no busy", busy, 0);
    readOne("R6 no latch array kept", 9'h000, 8'h10);
    oneByteCmd(8'h06);
    writeAllowed = 1'b0;
    writeSeq(9'h001, 1, 8'h99);
    check("R6 blocked no busy", busy, 0);
    writeAllowed = 1'b1;
    readOne("R6 blocked array kept", 9'h001, 8'h11);
    readStatus(s);
    check("R6 latch kept", s, 8'h02);
    writeOpen(9'h000);
    sendByte(8'h55);
    endFrame(1'b1);
    check("R7 mid-byte dropped", busy, 0);
    readOne("R7 mid-byte array kept", 9'h000, 8'h10);
    writeOpen(9'h000);
    endFrame(1'b0);
    check("R7 no data dropped", busy, 0);
    oneByteCmd(8'h04);
  endtask

  task automatic testBusyQuiet();
    logic [7:0] s;
    int n;
    oneByteCmd(8'h06);
    writeSeq(9'h050, 1, 8'h60);
    oneByteCmd(8'h04);
    readStatus(s);
    check("R10 latch op ignored while busy", s, 8'h03);
    readOpen(9'h000);
    check("R10 read ignored while busy", txData, 8'hFF);
    endFrame(1'b0);
    waitIdle(n);
    readStatus(s);
    check("R9 latch cleared after cycle", s, 8'h00);
    readOne("R8 data after cycle", 9'h050, 8'h60);
  endtask

  task automatic testStatusWrite();
    logic [7:0] s;
    int n;
    startFrame();
    sendByte(8'h01);
    sendByte(8'hFF);
    endFrame(1'b0);
    check("R11 no latch no busy", busy, 0);
    check("R11 no latch protEnable", protEnable, 0);
    oneByteCmd(8'h06);
    startFrame();
    sendByte(8'h01);
    sendByte(8'hFF);
    endFrame(1'b0);
    check("R11 busy raised", busy, 1);
    check("R11 not applied during cycle", protEnable, 0);
    waitIdle(n);
    check("R11 protEnable", protEnable, 1);
    check("R11 blockProt", blockProt, 3);
    readStatus(s);
    check("R11 R3 status", s, 8'h8C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLatch();
    testWriteRead();
    testOverflow();
    testGating();
    testBusyQuiet();
    testStatusWrite();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule